// File: doc/BRIEF.md
# PCI Bridge Parity Error Handler

This block watches both sides of a PCI-to-PCI bridge for parity faults. On the primary bus it checks every address phase and the data phases of Type 0 configuration writes that target the bridge itself. On the secondary bus it checks every address phase. From the results it decides whether the bridge must refuse to claim a transaction. It raises the primary parity-error and system-error pin requests, and it keeps the sticky parity bits of the primary and secondary status registers.

The two sides take their parity-response enable from different places. The primary side uses the command register bit. The secondary side uses the bridge control register bit. System errors from either side leave through the one primary system-error request.

A small generator also produces the parity bit for data forwarded between the buses. A bad parity condition seen on the source bus therefore reappears unchanged on the destination bus. The block has no data stream with back-pressure: every pin is a plain per-cycle strobe or level.

Top module: `pbe_parity_ctl`

## Requirements
- R1: Parity is even over AD and C/BE# together: a phase is in error when the PAR value sampled on the clock edge after the phase strobe differs from the XOR of all AD and C/BE# bits of that phase. Phases with matching PAR leave every output and status bit untouched.
- R2: A primary address strobe is sampled on edge k. If that address phase has a parity error and the command register parity-response bit is 1, `p_claim_block` is high for exactly the cycle between edges k+1 and k+2. With that bit 0, it stays low.
- R3: A secondary address parity error drives `s_claim_block` in the same cycle only when the bridge control parity-response bit is 1. The command register parity-response bit has no effect on it.
- R4: A primary address or configuration-write data parity error sets `pri_dpe` after edge k+2, and a secondary address parity error sets `sec_dpe` then. Both happen whatever the enable bits are.
- R5: An address parity error on either side raises `p_serr_req` for one cycle after edge k+2 and sets `pri_sse` at the same edge. This happens only if the command SERR enable is 1 and the matching side's parity-response bit is 1 (command bit for the primary side, bridge control bit for the secondary side). Errors on both sides in the same cycle give a single one-cycle pulse.
- R6: A data parity error in a primary configuration write raises `p_perr_req` for one cycle after edge k+2, only when the command parity-response bit is 1. It never blocks the claim.
- R7: Status bits are write-1-to-clear. On a write strobe, `pri_sts_wdata` bit 0 clears `pri_dpe`, bit 1 clears `pri_sse`, and `sec_sts_wdata` clears `sec_dpe`. A 0 bit leaves its status bit alone. A set and a clear on the same edge leave the bit set.
- R8: When `fwd_vld` is sampled high, `fwd_par` takes, from the next cycle on, the XOR of `fwd_ad`, `fwd_cbe_n` and `fwd_src_bad`. It therefore keeps a good or bad parity condition unchanged.
- R9: While reset is held, all request, claim-block, status and forward parity outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| p_ad | input | 32 | Primary AD bus |
| p_cbe_n | input | 4 | Primary C/BE# bus |
| p_par | input | 1 | Primary PAR, one clock after the phase |
| p_addr_vld | input | 1 | Primary address phase strobe |
| p_cfgw_vld | input | 1 | Primary data phase of a Type 0 config write to the bridge |
| s_ad | input | 32 | Secondary AD bus |
| s_cbe_n | input | 4 | Secondary C/BE# bus |
| s_par | input | 1 | Secondary PAR, one clock after the phase |
| s_addr_vld | input | 1 | Secondary address phase strobe |
| cmd_per_en | input | 1 | Command register parity-response enable |
| cmd_serr_en | input | 1 | Command register SERR enable |
| bctl_per_en | input | 1 | Bridge control parity-response enable |
| pri_sts_wr | input | 1 | Primary status write strobe |
| pri_sts_wdata | input | 2 | Primary status write-1-to-clear data (bit 0 DPE, bit 1 SSE) |
| sec_sts_wr | input | 1 | Secondary status write strobe |
| sec_sts_wdata | input | 1 | Secondary status write-1-to-clear data (DPE) |
| fwd_vld | input | 1 | Forwarded phase strobe |
| fwd_ad | input | 32 | Forwarded AD value |
| fwd_cbe_n | input | 4 | Forwarded C/BE# value |
| fwd_src_bad | input | 1 | Source bus parity was bad for this phase |
| p_claim_block | output | 1 | Do not assert primary DEVSEL# |
| s_claim_block | output | 1 | Do not assert secondary DEVSEL# |
| p_perr_req | output | 1 | Drive primary PERR# low this cycle |
| p_serr_req | output | 1 | Drive primary SERR# low this cycle |
| pri_dpe | output | 1 | Primary detected parity error status |
| pri_sse | output | 1 | Primary signaled system error status |
| sec_dpe | output | 1 | Secondary detected parity error status |
| fwd_par | output | 1 | Parity to drive on the destination bus |

## Verification
Two pairs of functions can land on the same clock edge. The first is a status set and a software clear. The bench asserts the clear strobe in the cycle after PAR is sampled, so it meets the edge that sets the bit, and it expects the bit to stay set. The second is address errors on both buses at once. The bench launches primary and secondary address phases with bad PAR in the same cycle. It expects one single-cycle system-error pulse, one signaled-system-error bit, and both detected-parity bits set.

// File: rtl/pbe_pkg.sv
package pbe_pkg;
  typedef enum logic [1:0] {
    PH_NONE = 2'd0,
    PH_ADDR = 2'd1,
    PH_CFGW = 2'd2
  } phase_e;

  localparam int unsigned NSTS = 3;
  localparam int unsigned ST_PDPE = 0;
  localparam int unsigned ST_PSSE = 1;
  localparam int unsigned ST_SDPE = 2;
endpackage

// File: rtl/pbe_par_check.sv
module pbe_par_check
  import pbe_pkg::*;
#(
  parameter int unsigned AD_W = 32,
  parameter int unsigned BE_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AD_W-1:0] ad,
  input  logic [BE_W-1:0] cbe_n,
  input  logic            par,
  input  phase_e          ph,
  output logic            err,
  output phase_e          err_ph
);
  localparam int unsigned VW = AD_W + BE_W;

  logic [VW-1:0] vec;
  logic          exp_q;
  phase_e        ph_q;

  assign vec = {ad, cbe_n};

  // stage 1: remember expected parity and phase kind
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_q <= 1'b0;
      ph_q  <= PH_NONE;
    end else begin
      exp_q <= ^vec;
      ph_q  <= ph;
    end
  end

  // stage 2: compare against PAR arriving one clock later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err    <= 1'b0;
      err_ph <= PH_NONE;
    end else begin
      err    <= (ph_q != PH_NONE) && (par != exp_q);
      err_ph <= ph_q;
    end
  end
endmodule

// File: rtl/pbe_fwd_par.sv
module pbe_fwd_par #(
  parameter int unsigned AD_W = 32,
  parameter int unsigned BE_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            vld,
  input  logic [AD_W-1:0] ad,
  input  logic [BE_W-1:0] cbe_n,
  input  logic            src_bad,
  output logic            par
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   par <= 1'b0;
    else if (vld) par <= (^{ad, cbe_n}) ^ src_bad;
  end
endmodule

// File: rtl/pbe_err_report.sv
module pbe_err_report
  import pbe_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       p_aerr,
  input  logic       p_derr,
  input  logic       s_aerr,
  input  logic       cmd_per_en,
  input  logic       cmd_serr_en,
  input  logic       bctl_per_en,
  input  logic       pri_sts_wr,
  input  logic [1:0] pri_sts_wdata,
  input  logic       sec_sts_wr,
  input  logic       sec_sts_wdata,
  output logic       perr_req,
  output logic       serr_req,
  output logic [NSTS-1:0] sts
);
  logic            serr_set;
  logic [NSTS-1:0] set_v;
  logic [NSTS-1:0] clr_v;

  assign serr_set = cmd_serr_en &
                    ((p_aerr & cmd_per_en) | (s_aerr & bctl_per_en));

  always_comb begin
    set_v          = '0;
    clr_v          = '0;
    set_v[ST_PDPE] = p_aerr | p_derr;
    set_v[ST_PSSE] = serr_set;
    set_v[ST_SDPE] = s_aerr;
    clr_v[ST_PDPE] = pri_sts_wr & pri_sts_wdata[0];
    clr_v[ST_PSSE] = pri_sts_wr & pri_sts_wdata[1];
    clr_v[ST_SDPE] = sec_sts_wr & sec_sts_wdata;
  end

  // sticky bits; a set on the same edge beats a clear
  for (genvar i = 0; i < NSTS; i++) begin : g_sts
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sts[i] <= 1'b0;
      else        sts[i] <= set_v[i] | (sts[i] & ~clr_v[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      perr_req <= 1'b0;
      serr_req <= 1'b0;
    end else begin
      perr_req <= p_derr & cmd_per_en;
      serr_req <= serr_set;
    end
  end
endmodule

// File: rtl/pbe_parity_ctl.sv
module pbe_parity_ctl
  import pbe_pkg::*;
#(
  parameter int unsigned AD_W = 32,
  parameter int unsigned BE_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AD_W-1:0] p_ad,
  input  logic [BE_W-1:0] p_cbe_n,
  input  logic            p_par,
  input  logic            p_addr_vld,
  input  logic            p_cfgw_vld,
  input  logic [AD_W-1:0] s_ad,
  input  logic [BE_W-1:0] s_cbe_n,
  input  logic            s_par,
  input  logic            s_addr_vld,
  input  logic            cmd_per_en,
  input  logic            cmd_serr_en,
  input  logic            bctl_per_en,
  input  logic            pri_sts_wr,
  input  logic [1:0]      pri_sts_wdata,
  input  logic            sec_sts_wr,
  input  logic            sec_sts_wdata,
  input  logic            fwd_vld,
  input  logic [AD_W-1:0] fwd_ad,
  input  logic [BE_W-1:0] fwd_cbe_n,
  input  logic            fwd_src_bad,
  output logic            p_claim_block,
  output logic            s_claim_block,
  output logic            p_perr_req,
  output logic            p_serr_req,
  output logic            pri_dpe,
  output logic            pri_sse,
  output logic            sec_dpe,
  output logic            fwd_par
);
  phase_e          p_ph, s_ph, p_err_ph, s_err_ph;
  logic            p_err, s_err;
  logic            p_aerr, p_derr, s_aerr;
  logic [NSTS-1:0] sts;

  assign p_ph = p_addr_vld ? PH_ADDR : (p_cfgw_vld ? PH_CFGW : PH_NONE);
  assign s_ph = s_addr_vld ? PH_ADDR : PH_NONE;

  pbe_par_check #(.AD_W(AD_W), .BE_W(BE_W)) u_pchk (
    .clk(clk), .rst_n(rst_n), .ad(p_ad), .cbe_n(p_cbe_n), .par(p_par),
    .ph(p_ph), .err(p_err), .err_ph(p_err_ph)
  );

  pbe_par_check #(.AD_W(AD_W), .BE_W(BE_W)) u_schk (
    .clk(clk), .rst_n(rst_n), .ad(s_ad), .cbe_n(s_cbe_n), .par(s_par),
    .ph(s_ph), .err(s_err), .err_ph(s_err_ph)
  );

  assign p_aerr = p_err & (p_err_ph == PH_ADDR);
  assign p_derr = p_err & (p_err_ph == PH_CFGW);
  assign s_aerr = s_err & (s_err_ph == PH_ADDR);

  // claim suppression uses each side's own parity-response enable
  assign p_claim_block = p_aerr & cmd_per_en;
  assign s_claim_block = s_aerr & bctl_per_en;

  pbe_err_report u_rep (
    .clk(clk), .rst_n(rst_n),
    .p_aerr(p_aerr), .p_derr(p_derr), .s_aerr(s_aerr),
    .cmd_per_en(cmd_per_en), .cmd_serr_en(cmd_serr_en),
    .bctl_per_en(bctl_per_en),
    .pri_sts_wr(pri_sts_wr), .pri_sts_wdata(pri_sts_wdata),
    .sec_sts_wr(sec_sts_wr), .sec_sts_wdata(sec_sts_wdata),
    .perr_req(p_perr_req), .serr_req(p_serr_req), .sts(sts)
  );

  assign pri_dpe = sts[ST_PDPE];
  assign pri_sse = sts[ST_PSSE];
  assign sec_dpe = sts[ST_SDPE];

  pbe_fwd_par #(.AD_W(AD_W), .BE_W(BE_W)) u_fwd (
    .clk(clk), .rst_n(rst_n), .vld(fwd_vld), .ad(fwd_ad),
    .cbe_n(fwd_cbe_n), .src_bad(fwd_src_bad), .par(fwd_par)
  );
endmodule

// File: rtl/pbe_parity_sva.sv
module pbe_parity_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       p_addr_vld,
  input logic       s_addr_vld,
  input logic       cmd_per_en,
  input logic       cmd_serr_en,
  input logic       bctl_per_en,
  input logic       pri_sts_wr,
  input logic [1:0] pri_sts_wdata,
  input logic       p_claim_block,
  input logic       s_claim_block,
  input logic       p_perr_req,
  input logic       p_serr_req,
  input logic       pri_dpe,
  input logic       pri_sse
);
  p_block_needs_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
    p_claim_block |-> cmd_per_en);

  p_block_after_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    p_claim_block |-> $past(p_addr_vld, 2));

  p_sblock_own_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
    s_claim_block |-> (bctl_per_en && $past(s_addr_vld, 2)));

  p_serr_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    p_serr_req |-> ($past(cmd_serr_en) && pri_sse));

  p_perr_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    p_perr_req |-> $past(cmd_per_en));

  p_dpe_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pri_dpe && !(pri_sts_wr && pri_sts_wdata[0])) |=> pri_dpe);
endmodule

bind pbe_parity_ctl pbe_parity_sva u_sva (.*);

// File: tb/sim_pbe_parity_ctl.sv
`timescale 1ns/1ps
module sim_pbe_parity_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] p_ad = '0, s_ad = '0, fwd_ad = '0;
  logic [3:0]  p_cbe_n = '0, s_cbe_n = '0, fwd_cbe_n = '0;
  logic        p_par = 0, s_par = 0, p_addr_vld = 0, p_cfgw_vld = 0, s_addr_vld = 0;
  logic        cmd_per_en = 0, cmd_serr_en = 0, bctl_per_en = 0;
  logic        pri_sts_wr = 0, sec_sts_wr = 0, sec_sts_wdata = 0;
  logic [1:0]  pri_sts_wdata = '0;
  logic        fwd_vld = 0, fwd_src_bad = 0;
  logic        p_claim_block, s_claim_block, p_perr_req, p_serr_req;
  logic        pri_dpe, pri_sse, sec_dpe, fwd_par;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pbe_parity_ctl u0 (.*);

  // {side(1=sec), cfgw, corrupt, cmd_per, cmd_serr, bctl_per, ad, cbe_n}
  localparam logic [41:0] VEC [10] = '{
    {1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,32'hA5A5_0F0F,4'h6},
    {1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,32'h1234_5678,4'h3},
    {1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,32'hFFFF_0000,4'hE},
    {1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,32'h0000_0001,4'h0},
    {1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,32'hDEAD_BEEF,4'h7},
    {1'b1,1'b0,1'b1,1'b1,1'b1,1'b0,32'h8000_0000,4'hA},
    {1'b0,1'b1,1'b1,1'b1,1'b1,1'b1,32'hCAFE_F00D,4'h0},
    {1'b0,1'b1,1'b1,1'b0,1'b1,1'b1,32'h0F0F_F0F0,4'h5},
    {1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,32'h3333_CCCC,4'h9},
    {1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,32'h7777_1111,4'hB}
  };

  task automatic chk(input logic act, input logic exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b", what, act, exp);
    end
  endtask

  task automatic clear_all();
    @(negedge clk);
    pri_sts_wr = 1; pri_sts_wdata = 2'b11; sec_sts_wr = 1; sec_sts_wdata = 1;
    @(negedge clk);
    pri_sts_wr = 0; pri_sts_wdata = 2'b00; sec_sts_wr = 0; sec_sts_wdata = 0;
  endtask

  task automatic run_vec(input logic [41:0] v);
    logic side, cfg, cor, cper, cserr, bper;
    logic [31:0] ad;
    logic [3:0] cbe;
    logic e_pblk, e_sblk, e_serr, e_perr, e_pdpe, e_sdpe;
    {side, cfg, cor, cper, cserr, bper, ad, cbe} = v;
    e_pblk = !side && !cfg && cor && cper;
    e_sblk = side && cor && bper;
    e_serr = !cfg && cor && cserr && (side ? bper : cper);
    e_perr = cfg && cor && cper;
    e_pdpe = !side && cor;
    e_sdpe = side && cor;
    @(negedge clk);
    cmd_per_en = cper; cmd_serr_en = cserr; bctl_per_en = bper;
    if (side) begin s_ad = ad; s_cbe_n = cbe; s_addr_vld = 1; end
    else begin
      p_ad = ad; p_cbe_n = cbe;
      if (cfg) p_cfgw_vld = 1; else p_addr_vld = 1;
    end
    @(negedge clk);
    s_addr_vld = 0; p_addr_vld = 0; p_cfgw_vld = 0;
    if (side) s_par = (^{ad, cbe}) ^ cor; else p_par = (^{ad, cbe}) ^ cor;
    @(negedge clk);
    chk(p_claim_block, e_pblk, "R2 p_claim_block");
    chk(s_claim_block, e_sblk, "R3 s_claim_block");
    @(negedge clk);
    chk(p_serr_req, e_serr, "R5 p_serr_req");
    chk(pri_sse, e_serr, "R5 pri_sse");
    chk(p_perr_req, e_perr, "R6 p_perr_req");
    chk(pri_dpe, e_pdpe, "R1/R4 pri_dpe");
    chk(sec_dpe, e_sdpe, "R1/R4 sec_dpe");
    @(negedge clk);
    chk(p_serr_req, 1'b0, "R5 serr one clock");
    chk(p_perr_req, 1'b0, "R6 perr one clock");
    clear_all();
    chk(pri_dpe | pri_sse | sec_dpe, 1'b0, "R7 clear by write 1");
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(p_claim_block | s_claim_block | p_perr_req | p_serr_req, 1'b0, "R9 reset requests");
    chk(pri_dpe | pri_sse | sec_dpe | fwd_par, 1'b0, "R9 reset status");
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < 10; i++) run_vec(VEC[i]);

    // R7: writing 0 leaves a set bit alone
    run_vec_keep();
    @(negedge clk);
    pri_sts_wr = 1; pri_sts_wdata = 2'b10;
    @(negedge clk);
    pri_sts_wr = 0; pri_sts_wdata = 2'b00;
    chk(pri_dpe, 1'b1, "R7 zero write keeps pri_dpe");
    clear_all();

    // R7: set and clear on the same edge -> stays set
    @(negedge clk);
    cmd_per_en = 0; cmd_serr_en = 0; p_ad = 32'h0000_00FF; p_cbe_n = 4'h1; p_addr_vld = 1;
    @(negedge clk);
    p_addr_vld = 0; p_par = ~(^{p_ad, p_cbe_n});
    @(negedge clk);
    pri_sts_wr = 1; pri_sts_wdata = 2'b01;
    @(negedge clk);
    pri_sts_wr = 0; pri_sts_wdata = 2'b00;
    chk(pri_dpe, 1'b1, "R7 set beats clear");
    clear_all();

    // R5: both sides in error in the same cycle
    @(negedge clk);
    cmd_per_en = 1; cmd_serr_en = 1; bctl_per_en = 1;
    p_ad = 32'h5555_AAAA; p_cbe_n = 4'h2; p_addr_vld = 1;
    s_ad = 32'h0101_0101; s_cbe_n = 4'hC; s_addr_vld = 1;
    @(negedge clk);
    p_addr_vld = 0; s_addr_vld = 0;
    p_par = ~(^{p_ad, p_cbe_n}); s_par = ~(^{s_ad, s_cbe_n});
    @(negedge clk);
    chk(p_claim_block & s_claim_block, 1'b1, "R2/R3 both blocked");
    @(negedge clk);
    chk(p_serr_req, 1'b1, "R5 merged serr");
    chk(pri_sse & pri_dpe & sec_dpe, 1'b1, "R4/R5 dual status");
    @(negedge clk);
    chk(p_serr_req, 1'b0, "R5 merged serr single pulse");
    clear_all();

    // R8: forwarded parity, good and bad source
    @(negedge clk);
    fwd_ad = 32'h1357_9BDF; fwd_cbe_n = 4'h4; fwd_src_bad = 0; fwd_vld = 1;
    @(negedge clk);
    chk(fwd_par, ^{32'h1357_9BDF, 4'h4}, "R8 forward good");
    fwd_ad = 32'h2468_ACE0; fwd_cbe_n = 4'h8; fwd_src_bad = 1;
    @(negedge clk);
    chk(fwd_par, ~(^{32'h2468_ACE0, 4'h8}), "R8 forward bad");
    fwd_vld = 0; fwd_ad = 32'hFFFF_FFFF;
    @(negedge clk);
    chk(fwd_par, ~(^{32'h2468_ACE0, 4'h8}), "R8 hold without strobe");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  // primary address error left set (no serr), used by the zero-write test
  task automatic run_vec_keep();
    @(negedge clk);
    cmd_per_en = 0; cmd_serr_en = 0; p_ad = 32'h0000_0F00; p_cbe_n = 4'h0; p_addr_vld = 1;
    @(negedge clk);
    p_addr_vld = 0; p_par = ~(^{p_ad, p_cbe_n});
    repeat (2) @(negedge clk);
    chk(pri_dpe, 1'b1, "R4 pri_dpe without enables");
  endtask
endmodule